// File: doc/BRIEF.md
# Dual-Buffer Packet Commit Controller

This block sits on the device side of a bulk OUT pipe. Packets arrive as a byte stream with a last marker. The block collects them into two equal buffers that take turns. It hands a buffer to the consumer port only when there is a reason to. A buffer is handed over when it is completely full, when a packet shorter than the maximum packet size ends inside it, or when an empty (zero-length) packet arrives. Full-size packets that do not fill the buffer are stored without any visible change at the consumer side.

The consumer watches a single not-empty flag. While the flag is high it pulls bytes one at a time, in the order they were written. The flag stays high until the consumer has drained the committed buffer to its recorded byte count. If both buffers are committed and neither has been drained, the producer side stops accepting data.

The buffer size and the maximum packet size are parameters. The buffer size must be a power of two and a multiple of the packet size.

Top module: `pingpong_commit`

## Requirements
- R1: After reset, `outNotEmpty` is 0, `inReady` is 1 and `rdValid` is 0.
- R2: Full-size packets of exactly `MAX_PKT` bytes leave `outNotEmpty` at 0 until the byte that completes `BUF_BYTES` is accepted. The flag reads 1 in the cycle after that byte's clock edge.
- R3: A packet of 1 to `MAX_PKT`-1 bytes commits the buffer at its last byte (`inLast`=1). The flag is 1 in the cycle after that edge, whatever data the buffer held before.
- R4: An accepted beat with `inEmpty`=1 is a zero-length packet. It writes no byte, because `inData` is ignored. It commits the current buffer with exactly the bytes already in it.
- R5: While the flag is 1, `rdEn`=1 returns the next stored byte on `rdData` with `rdValid`=1 one cycle later. Exactly the committed count of bytes is returned, in write order, and `rdLast`=1 only on the final one.
- R6: Once raised, `outNotEmpty` stays 1 until the final byte of the committed buffer has been read. It is 1 after every read except the last.
- R7: A buffer committed with zero bytes raises the flag. A single `rdEn` drains it, returns no byte (`rdValid`=0) and clears the flag.
- R8: While both buffers are committed and undrained, `inReady` is 0 and no byte is accepted. `inReady` returns to 1 after one buffer is drained.
- R9: Buffers are committed and drained in strict alternation. The second committed buffer's bytes follow the first buffer's bytes at the consumer, and the flag stays 1 between them.
- R10: `rdEn` while `outNotEmpty` is 0 has no effect: `rdValid` stays 0 and later drains are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Producer beat valid |
| inReady | output | 1 | Producer beat may be accepted |
| inData | input | DW | Producer byte |
| inLast | input | 1 | Beat is the final byte of its packet |
| inEmpty | input | 1 | Beat is a zero-length packet (no data) |
| rdEn | input | 1 | Consumer read request |
| rdData | output | DW | Consumer byte |
| rdValid | output | 1 | `rdData` holds a byte |
| rdLast | output | 1 | Byte is the final byte of its buffer |
| outNotEmpty | output | 1 | A committed buffer is waiting for the consumer |

## Verification
The hardest state to reach is both buffers committed at once, with the producer still offering data. That is the only state in which `inReady` falls. The stimulus commits two short packets back to back without reading. It holds a valid beat against the stalled input, then drains the first buffer to show that the flag bridges into the second one. The zero-byte buffer is also awkward to reach. It needs a zero-length packet that arrives right after a drain, and it is reached in the table walk.

// File: rtl/pingpong_commit_pkg.sv
package pingpong_commit_pkg;
  // Strobes from control to datapath.
  typedef struct packed {
    logic wrEn;
    logic wrSel;
    logic rdEn;
    logic rdSel;
    logic rdLast;
  } ctlStrb_t;
endpackage

// File: rtl/pingpong_commit_ctrl.sv
module pingpong_commit_ctrl
  import pingpong_commit_pkg::*;
#(
  parameter int BUF_BYTES = 64,
  parameter int MAX_PKT   = 16,
  localparam int AW = $clog2(BUF_BYTES),
  localparam int CW = $clog2(BUF_BYTES + 1),
  localparam int PW = $clog2(MAX_PKT + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  input  logic          inEmpty,
  input  logic          inLast,
  output logic          inReady,
  input  logic          rdEn,
  output logic          outNotEmpty,
  output ctlStrb_t      strb,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr
);
  logic          wrSel, rdSel;
  logic [1:0]    committed;
  logic [CW-1:0] fill;
  logic [CW-1:0] count [2];
  logic [PW-1:0] pktCnt;
  logic [AW-1:0] rdPtr;

  logic accept, dataBeat, zlpHit, fullHit, shortHit, commit;
  logic rdGo, zeroDrain, byteRead, lastRead, releaseBuf;
  logic [CW-1:0] fillNext, curCount, rdPtrNext;
  logic [PW-1:0] pktNext;

  assign inReady     = !committed[wrSel];
  assign outNotEmpty = committed[rdSel];

  // Producer side commit decision
  always_comb begin
    accept   = inValid && inReady;
    dataBeat = accept && !inEmpty;
    zlpHit   = accept && inEmpty;
    fillNext = fill + CW'(1);
    pktNext  = pktCnt + PW'(1);
    fullHit  = dataBeat && (fillNext == CW'(BUF_BYTES));
    shortHit = dataBeat && inLast && (pktNext < PW'(MAX_PKT));
    commit   = fullHit || shortHit || zlpHit;
  end

  // Consumer side drain decision
  always_comb begin
    curCount   = count[rdSel];
    rdPtrNext  = CW'(rdPtr) + CW'(1);
    rdGo       = rdEn && committed[rdSel];
    zeroDrain  = rdGo && (curCount == '0);
    byteRead   = rdGo && (curCount != '0);
    lastRead   = byteRead && (rdPtrNext == curCount);
    releaseBuf = zeroDrain || lastRead;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrSel     <= 1'b0;
      rdSel     <= 1'b0;
      committed <= '0;
      fill      <= '0;
      pktCnt    <= '0;
      rdPtr     <= '0;
      for (int i = 0; i < 2; i++) count[i] <= '0;
    end else begin
      if (commit) begin
        committed[wrSel] <= 1'b1;
        count[wrSel]     <= dataBeat ? fillNext : fill;
        fill             <= '0;
        wrSel            <= ~wrSel;
      end else if (dataBeat) begin
        fill <= fillNext;
      end

      if (dataBeat)    pktCnt <= inLast ? '0 : pktNext;
      else if (zlpHit) pktCnt <= '0;

      if (byteRead) rdPtr <= lastRead ? '0 : rdPtr + AW'(1);

      if (releaseBuf) begin
        committed[rdSel] <= 1'b0;
        rdSel            <= ~rdSel;
      end
    end
  end

  always_comb begin
    strb.wrEn   = dataBeat;
    strb.wrSel  = wrSel;
    strb.rdEn   = byteRead;
    strb.rdSel  = rdSel;
    strb.rdLast = lastRead;
    wrAddr      = fill[AW-1:0];
    rdAddr      = rdPtr;
  end

  // R8: no buffer free means the producer is stalled
  a_r8_stall_when_both: assert property (@(posedge clk) disable iff (!rstN)
    (committed == 2'b11) |-> !inReady);
  // R2: a full-size packet that does not fill the buffer keeps ownership
  a_r2_full_pkt_silent: assert property (@(posedge clk) disable iff (!rstN)
    (dataBeat && inLast && !shortHit && !fullHit) |=> (wrSel == $past(wrSel)));
  // R3: a short packet hands its buffer over
  a_r3_short_commit: assert property (@(posedge clk) disable iff (!rstN)
    shortHit |=> ((wrSel != $past(wrSel)) && committed[$past(wrSel)]));
  // R6: flag holds until the buffer is released
  a_r6_flag_hold: assert property (@(posedge clk) disable iff (!rstN)
    (outNotEmpty && !releaseBuf) |=> outNotEmpty);
  // R9: drains alternate between buffers
  a_r9_alternate: assert property (@(posedge clk) disable iff (!rstN)
    releaseBuf |=> (rdSel != $past(rdSel)));
  // R5: a recorded count never exceeds the buffer
  a_r5_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    outNotEmpty |-> (curCount <= CW'(BUF_BYTES)));
endmodule

// File: rtl/pingpong_commit_dp.sv
module pingpong_commit_dp
  import pingpong_commit_pkg::*;
#(
  parameter int DW        = 8,
  parameter int BUF_BYTES = 64,
  localparam int AW    = $clog2(BUF_BYTES),
  localparam int DEPTH = 2 * BUF_BYTES
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctlStrb_t      strb,
  input  logic [AW-1:0] wrAddr,
  input  logic [AW-1:0] rdAddr,
  input  logic [DW-1:0] inData,
  output logic [DW-1:0] rdData,
  output logic          rdValid,
  output logic          rdLast
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (strb.wrEn) mem[{strb.wrSel, wrAddr}] <= inData;
    if (strb.rdEn) rdData <= mem[{strb.rdSel, rdAddr}];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdLast  <= 1'b0;
    end else begin
      rdValid <= strb.rdEn;
      rdLast  <= strb.rdLast;
    end
  end

  // R5: returned bytes follow a read one cycle earlier
  a_r5_valid_after_read: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(strb.rdEn));
  // R5: the end marker only rides on a valid byte
  a_r5_last_with_valid: assert property (@(posedge clk) disable iff (!rstN)
    rdLast |-> rdValid);
endmodule

// File: rtl/pingpong_commit.sv
module pingpong_commit
  import pingpong_commit_pkg::*;
#(
  parameter int DW        = 8,
  parameter int BUF_BYTES = 64,
  parameter int MAX_PKT   = 16,
  localparam int AW = $clog2(BUF_BYTES)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  output logic          inReady,
  input  logic [DW-1:0] inData,
  input  logic          inLast,
  input  logic          inEmpty,
  input  logic          rdEn,
  output logic [DW-1:0] rdData,
  output logic          rdValid,
  output logic          rdLast,
  output logic          outNotEmpty
);
  ctlStrb_t      strb;
  logic [AW-1:0] wrAddr, rdAddr;

  pingpong_commit_ctrl #(.BUF_BYTES(BUF_BYTES), .MAX_PKT(MAX_PKT)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inEmpty(inEmpty), .inLast(inLast),
    .inReady(inReady), .rdEn(rdEn), .outNotEmpty(outNotEmpty), .strb(strb),
    .wrAddr(wrAddr), .rdAddr(rdAddr)
  );

  pingpong_commit_dp #(.DW(DW), .BUF_BYTES(BUF_BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .inData(inData), .rdData(rdData), .rdValid(rdValid), .rdLast(rdLast)
  );
endmodule

// File: tb/pingpong_commit_tb.sv
module pingpong_commit_tb;
  localparam int DW = 8, BUF = 64, MAXP = 16;

  logic clk = 0, rstN = 0;
  logic inValid = 0, inLast = 0, inEmpty = 0, rdEn = 0;
  logic [DW-1:0] inData = '0;
  logic inReady, rdValid, rdLast, outNotEmpty;
  logic [DW-1:0] rdData;

  int checks = 0, failures = 0, cycles = 0;
  logic [7:0] q [0:1023];
  int wp = 0, rp = 0, pend = 0;
  logic [7:0] seqVal = 8'h10;

  // {length (0 = zero-length packet), expected flag after, drain afterwards}
  localparam logic [9:0] TBL [11] = '{
    {8'd16, 1'b0, 1'b0}, {8'd16, 1'b0, 1'b0}, {8'd16, 1'b0, 1'b0}, {8'd16, 1'b1, 1'b1},
    {8'd5,  1'b1, 1'b1}, {8'd16, 1'b0, 1'b0}, {8'd3,  1'b1, 1'b1}, {8'd0,  1'b1, 1'b1},
    {8'd16, 1'b0, 1'b0}, {8'd0,  1'b1, 1'b1}, {8'd15, 1'b1, 1'b1}
  };

  pingpong_commit #(.DW(DW), .BUF_BYTES(BUF), .MAX_PKT(MAXP)) u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inData(inData),
    .inLast(inLast), .inEmpty(inEmpty), .rdEn(rdEn), .rdData(rdData),
    .rdValid(rdValid), .rdLast(rdLast), .outNotEmpty(outNotEmpty)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 50000) begin
      failures = failures + 1;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 50000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic sendPkt(input int len);
    if (len == 0) begin
      inValid = 1; inEmpty = 1; inLast = 1; inData = 8'hEE;
      @(posedge clk); @(negedge clk);
    end else begin
      for (int b = 0; b < len; b++) begin
        inValid = 1; inEmpty = 0; inLast = (b == len - 1); inData = seqVal;
        q[wp] = seqVal; wp++; seqVal = seqVal + 8'd7;
        @(posedge clk); @(negedge clk);
      end
      pend += len;
    end
    inValid = 0; inEmpty = 0; inLast = 0;
  endtask

  task automatic drain(input int n);
    if (n == 0) begin
      rdEn = 1; @(posedge clk); @(negedge clk); rdEn = 0;
      chk(rdValid == 0, "R7 zero drain no byte", rdValid, 0);
      chk(outNotEmpty == 0, "R7 zero drain clears flag", outNotEmpty, 0);
    end else begin
      for (int k = 0; k < n; k++) begin
        rdEn = 1; @(posedge clk); @(negedge clk); rdEn = 0;
        chk(rdValid == 1, "R5 byte valid", rdValid, 1);
        chk(rdData == q[rp], "R5 byte order", rdData, q[rp]);
        rp++;
        chk(rdLast == (k == n - 1), "R5 last marker", rdLast, (k == n - 1));
        if (k < n - 1) chk(outNotEmpty == 1, "R6 flag held mid drain", outNotEmpty, 1);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(outNotEmpty == 0, "R1 flag in reset", outNotEmpty, 0);
    rstN = 1;
    @(negedge clk);
    chk(outNotEmpty == 0, "R1 flag after reset", outNotEmpty, 0);
    chk(inReady == 1, "R1 ready after reset", inReady, 1);
    chk(rdValid == 0, "R1 no data after reset", rdValid, 0);

    // R10: reads against an empty flag do nothing
    rdEn = 1; @(posedge clk); @(negedge clk); rdEn = 0;
    chk(rdValid == 0, "R10 read ignored", rdValid, 0);
    chk(outNotEmpty == 0, "R10 flag still low", outNotEmpty, 0);

    // Table walk covers R2, R3, R4, R7
    for (int i = 0; i < 11; i++) begin
      int len;
      string tag;
      len = int'(TBL[i][9:2]);
      tag = (len == 0) ? "R4 zero-length commit" :
            (len < MAXP) ? "R3 short commit" : "R2 full-size packet";
      sendPkt(len);
      chk(outNotEmpty == TBL[i][1], tag, outNotEmpty, TBL[i][1]);
      if (TBL[i][0]) begin
        drain(pend);
        pend = 0;
        chk(outNotEmpty == 0, "R6 flag low after drain", outNotEmpty, 0);
      end
    end

    // R8 / R9: both buffers committed, producer stalled
    sendPkt(2);
    pend = 0;
    sendPkt(3);
    pend = 0;
    chk(inReady == 0, "R8 stalled with both committed", inReady, 0);
    chk(outNotEmpty == 1, "R8 flag high", outNotEmpty, 1);
    inValid = 1; inLast = 1; inData = 8'h77;
    repeat (2) @(posedge clk);
    @(negedge clk);
    inValid = 0; inLast = 0;
    drain(2);
    chk(outNotEmpty == 1, "R9 flag bridges to second buffer", outNotEmpty, 1);
    chk(inReady == 1, "R8 ready after one drain", inReady, 1);
    drain(3);
    chk(outNotEmpty == 0, "R9 both drained", outNotEmpty, 0);
    chk(rdValid == 1 && rdLast == 1, "R8 stalled byte not stored", rdLast, 1);
    rdEn = 1; @(posedge clk); @(negedge clk); rdEn = 0;
    chk(rdValid == 0, "R10 read after drain ignored", rdValid, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule